// File: doc/BRIEF.md
# Multi-format synchronous serial port

This block moves data words between a small register-style host port and a four-wire synchronous serial link. It handles three framings with one shift engine: plain SPI with an active-low select, a four-wire synchronous format that marks each frame with a one-period frame-sync pulse, and a Microwire-style half-duplex exchange. The two queues on the host side each hold eight words.

As bus master it generates the serial clock from the system clock. As slave it takes the link clock, select and data on its inputs, synchronizes them, and shifts on their edges. Frames carry 4 to 16 data bits, sent MSB first. Received words are right-justified in the 16-bit read field. Software writes a control word, then pushes transmit words into the data address and pops received words from the same address. It polls a five-bit status word for progress.

Top module: `ssp_port`

## Requirements
- R1: After reset the control register (address 0) reads 0 and the status register (address 2) reads 0x0003. sel_o is high, and sclk_o and sdo_oe are low. A value written to address 0 reads back unchanged. Control fields: [3:0] frame size minus one, [5:4] format (0 SPI, 1 four-wire sync, 2 Microwire), [6] master, [7] enable, [15:8] half-period divider.
- R2: Writes to address 1 enter an 8-word transmit queue, and a write made while it holds 8 words is dropped. Status bit 0 is transmit-queue-empty and bit 1 is transmit-queue-not-full.
- R3: As master, sclk_o idles low and has a period of 2*D system clocks, where D is the divider field. A field value of 0 acts as 1, giving a divide by 2.
- R4: In SPI master mode sel_o is low for the whole frame. The first data bit sits on sdo before the first rising sclk_o edge. sdi is sampled on every rising edge and sdo changes on falling edges. The N sampled bits, first bit most significant, are read from address 1 right-justified.
- R5: The frame length is the size field plus one. Field values 0 to 2 give 4-bit frames, and 15 gives 16-bit frames.
- R6: In four-wire sync master mode sel_o idles low. It is high for exactly one sclk_o period (one rising edge, sdo low) right before the MSB period, then frames N data bits as in R4.
- R7: In Microwire master mode the low 8 bits of the transmit word go out first, MSB first, and sdo is low afterwards. The frame lasts 8+N clocks, and only the last N sampled bits form the received word.
- R8: In SPI slave mode a falling sel_i starts a frame. The transmit word's MSB appears on sdo and later bits change after falling sclk_i edges. sdi is captured on rising sclk_i edges, and the word is queued after N rising edges.
- R9: As slave, sdo_oe is high only inside a selected frame. sclk_i activity while sel_i is high does not drive sdo_oe and pushes nothing to the receive queue.
- R10: A received word that arrives while the 8-word receive queue is full is discarded and sets status bit 3. The bit stays set until any write to address 2. Status bit 2 is receive-queue-not-empty.
- R11: Status bit 4 (busy) is high while a frame is in progress or a master-mode enabled port has queued transmit data.
- R12: Master transfers do not depend on sel_i. In slave mode sclk_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe, data valid the next cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered host read data |
| sclk_i | input | 1 | Serial clock from the master (slave mode) |
| sel_i | input | 1 | Select or frame sync from the master (slave mode) |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Generated serial clock (master mode) |
| sel_o | output | 1 | Generated select or frame sync (master mode) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
The hardest state to reach is a receive overrun. It needs eight completed frames left unread and then a ninth frame that finishes while the queue is still full. The bench loads nine words into the transmit queue while the port is disabled, which also shows the ninth write is dropped. It then enables the port with sdi held high, so eight all-ones words are received. A further frame is sent with sdi held low. Reading exactly eight all-ones words back and then finding the queue empty proves the all-zero word was discarded.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    FMT_SPI   = 2'd0,
    FMT_SYNC4 = 2'd1,
    FMT_MWIRE = 2'd2
  } fmt_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef struct packed {
    logic [7:0] half_div;
    logic       en;
    logic       master;
    fmt_e       fmt;
    logic [3:0] size_m1;
  } ctrl_t;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CNTW-1:0] cnt;
  logic            wr_ok, rd_ok;

  assign empty = (cnt == '0);
  assign full  = (cnt == CNTW'(DEPTH));
  assign rd_ok = pop && !empty;
  assign wr_ok = push && (!full || rd_ok);
  assign dout  = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      cnt <= cnt + CNTW'(wr_ok) - CNTW'(rd_ok);
    end
  end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
  import ssp_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         cfg,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_word,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          active,
  input  logic          sclk_i,
  input  logic          sel_i,
  input  logic          sdi,
  output logic          sclk_o,
  output logic          sel_o,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int SW = DW + CW;
  localparam int NW = $clog2(SW + 1);

  logic          ssi, mw;
  logic [NW-1:0] nbits, tot, cnt;
  logic [7:0]    half, dcnt;
  logic [SW-1:0] base, load_v, tx_sh, rx_sh, rx_next;
  logic [DW-1:0] src;
  logic          sync_slot, out_bit, sclk_r, sel_r;
  logic          sclk_m, sclk_s, sclk_p, sel_m, sel_s, sel_p, sdi_m, sdi_s;
  logic          s_rise, s_fall, sel_fall, smp;

  assign ssi   = (cfg.fmt == FMT_SYNC4);
  assign mw    = (cfg.fmt == FMT_MWIRE);
  assign nbits = (cfg.size_m1 < 4'd3) ? NW'(4) : NW'(cfg.size_m1) + NW'(1);
  assign tot   = mw ? nbits + NW'(CW) : nbits;
  assign half  = (cfg.half_div == 8'd0) ? 8'd1 : cfg.half_div;
  assign src   = tx_valid ? tx_word : '0;
  assign base  = {src, {CW{1'b0}}} << (NW'(DW) - nbits);

  always_comb begin
    if (mw && cfg.master)  load_v = {src[CW-1:0], {DW{1'b0}}};
    else if (mw)           load_v = base >> CW;
    else                   load_v = base;
  end

  assign s_rise   = sclk_s && !sclk_p;
  assign s_fall   = !sclk_s && sclk_p;
  assign sel_fall = sel_p && !sel_s;
  assign smp      = cfg.master ? sdi : sdi_s;
  assign rx_next  = {rx_sh[SW-2:0], smp};

  function automatic logic [DW-1:0] pick(input logic [SW-1:0] sh);
    logic [SW-1:0] v;
    if (mw && !cfg.master) v = (sh >> nbits) & SW'(8'hFF);
    else                   v = sh & ((SW'(1) << nbits) - SW'(1));
    return v[DW-1:0];
  endfunction

  assign sclk_o = sclk_r;
  assign sel_o  = sel_r;
  assign sdo    = out_bit;
  assign sdo_oe = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      {sclk_m, sclk_s, sclk_p, sdi_m, sdi_s} <= '0;
      {sel_m, sel_s, sel_p} <= 3'b111;
    end else begin
      {sclk_m, sclk_s, sclk_p} <= {sclk_i, sclk_m, sclk_s};
      {sel_m, sel_s, sel_p}    <= {sel_i, sel_m, sel_s};
      {sdi_m, sdi_s}           <= {sdi, sdi_m};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; sync_slot <= 1'b0; cnt <= '0; dcnt <= '0;
      sclk_r <= 1'b0; sel_r <= 1'b1; out_bit <= 1'b0;
      tx_sh <= '0; rx_sh <= '0; tx_pop <= 1'b0; rx_push <= 1'b0; rx_word <= '0;
    end else begin
      tx_pop  <= 1'b0;
      rx_push <= 1'b0;
      if (cfg.master) begin
        if (!active) begin
          sclk_r <= 1'b0; sel_r <= !ssi; out_bit <= 1'b0; dcnt <= '0;
          if (cfg.en && tx_valid) begin
            active <= 1'b1; tx_pop <= 1'b1; cnt <= '0; rx_sh <= '0;
            sync_slot <= ssi;
            sel_r     <= ssi;
            if (ssi) tx_sh <= load_v;
            else begin out_bit <= load_v[SW-1]; tx_sh <= load_v << 1; end
          end
        end else if (dcnt == half - 8'd1) begin
          dcnt <= '0;
          if (!sclk_r) begin
            sclk_r <= 1'b1;
            if (!sync_slot) rx_sh <= rx_next;
          end else begin
            sclk_r <= 1'b0;
            if (sync_slot) begin
              sync_slot <= 1'b0; sel_r <= 1'b0;
              out_bit <= tx_sh[SW-1]; tx_sh <= tx_sh << 1;
            end else if (cnt == tot - NW'(1)) begin
              active <= 1'b0; rx_push <= 1'b1; rx_word <= pick(rx_sh);
              sel_r <= !ssi; out_bit <= 1'b0;
            end else begin
              cnt <= cnt + NW'(1); out_bit <= tx_sh[SW-1]; tx_sh <= tx_sh << 1;
            end
          end
        end else begin
          dcnt <= dcnt + 8'd1;
        end
      end else begin
        sclk_r <= 1'b0; sel_r <= 1'b1; dcnt <= '0; sync_slot <= 1'b0;
        if (!active) begin
          out_bit <= 1'b0;
          if (cfg.en && ((!ssi && sel_fall) || (ssi && s_rise && sel_s))) begin
            active <= 1'b1; cnt <= '0; rx_sh <= '0; tx_pop <= tx_valid;
            if (ssi) tx_sh <= load_v;
            else begin out_bit <= load_v[SW-1]; tx_sh <= load_v << 1; end
          end
        end else if (!ssi && sel_s) begin
          active <= 1'b0; out_bit <= 1'b0;
        end else if (s_rise) begin
          rx_sh <= rx_next;
          if (cnt == tot - NW'(1)) begin
            active <= 1'b0; rx_push <= 1'b1; rx_word <= pick(rx_next);
          end else begin
            cnt <= cnt + NW'(1);
          end
        end else if (s_fall) begin
          out_bit <= tx_sh[SW-1]; tx_sh <= tx_sh << 1;
        end
      end
    end
  end
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sclk_i,
  input  logic          sel_i,
  input  logic          sdi,
  output logic          sclk_o,
  output logic          sel_o,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int CTRLW = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic          ovr_q;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic          tx_push, tx_pop, rx_push, rx_pop, active, busy;
  logic [DW-1:0] tx_head, rx_head, rx_word;
  logic [4:0]    stat_w;

  assign tx_push = bus_wr && (bus_addr == ADDR_DATA);
  assign rx_pop  = bus_rd && (bus_addr == ADDR_DATA) && !rx_empty;
  assign busy    = active || (ctrl_q.master && ctrl_q.en && !tx_empty);
  assign stat_w  = {busy, ovr_q, !rx_empty, !tx_full, tx_empty};

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .din(bus_wdata), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  ssp_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .cfg(ctrl_q),
    .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_word(rx_word), .active(active),
    .sclk_i(sclk_i), .sel_i(sel_i), .sdi(sdi),
    .sclk_o(sclk_o), .sel_o(sel_o), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ovr_q     <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRLW-1:0]);
      if (bus_wr && bus_addr == ADDR_STAT) ovr_q <= 1'b0;
      else if (rx_push && rx_full)         ovr_q <= 1'b1;
      if (bus_rd) begin
        case (bus_addr)
          ADDR_CTRL: bus_rdata <= DW'(ctrl_q);
          ADDR_DATA: bus_rdata <= rx_empty ? '0 : rx_head;
          ADDR_STAT: bus_rdata <= DW'(stat_w);
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ssp_port_chk.sv
module ssp_port_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] ctrl,
  input logic [4:0]  stat,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic        sclk_o,
  input logic        sel_o,
  input logic        sdo_oe
);
  logic is_master, is_spi, is_sync4;
  assign is_master = ctrl[6];
  assign is_spi    = (ctrl[5:4] == 2'd0);
  assign is_sync4  = (ctrl[5:4] == 2'd1);

  assert_slave_no_clock_R12: assert property (@(posedge clk) disable iff (rst)
    (!is_master && $past(!is_master)) |-> !sclk_o);

  assert_spi_select_R4: assert property (@(posedge clk) disable iff (rst)
    (is_master && is_spi && sclk_o) |-> !sel_o);

  assert_sync_pulse_clock_low_R6: assert property (@(posedge clk) disable iff (rst)
    (is_master && is_sync4 && $rose(sel_o)) |-> !sclk_o);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (stat[3] && !(bus_wr && bus_addr == 2'd2)) |=> stat[3]);

  assert_empty_not_full_R2: assert property (@(posedge clk) disable iff (rst)
    stat[0] |-> stat[1]);

  assert_drive_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> stat[4]);
endmodule

bind ssp_port ssp_port_chk u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl_q), .stat(stat_w),
  .bus_wr(bus_wr), .bus_addr(bus_addr),
  .sclk_o(sclk_o), .sel_o(sel_o), .sdo_oe(sdo_oe)
);

// File: tb/tb_ssp_port.sv
module tb_ssp_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0, bus_rdata;
  logic        sclk_i = 1'b0, sel_i = 1'b1, sdi;
  logic        sclk_o, sel_o, sdo, sdo_oe;

  ssp_port dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_i(sclk_i), .sel_i(sel_i),
    .sdi(sdi), .sclk_o(sclk_o), .sel_o(sel_o), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int checks = 0, errors = 0;

  // master-side link model
  logic [31:0] resp_vec = 32'd0, cap = 32'd0;
  int          rises = 0;
  logic        sdi_const_mode = 1'b0, sdi_const = 1'b0, slave_tb = 1'b0, sdi_drv = 1'b0;
  time         last_t = 0, prev_t = 0, fs_up = 0, fs_dn = 0;
  logic        sclk_seen = 1'b0;

  assign sdi = slave_tb ? sdi_drv :
               sdi_const_mode ? sdi_const :
               ((rises < 32) ? resp_vec[31 - rises] : 1'b0);

  always @(posedge sclk_o) begin
    cap    <= {cap[30:0], sdo};
    rises  <= rises + 1;
    prev_t <= last_t;
    last_t <= $time;
    if (slave_tb) sclk_seen <= 1'b1;
  end
  always @(posedge sel_o) fs_up = $time;
  always @(negedge sel_o) fs_dn = $time;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [3:0]  sz;
    logic [7:0]  half;
    logic [15:0] tx;
    logic [15:0] resp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd7,  8'd2, 16'h00A5, 16'h003C},
    '{2'd0, 4'd15, 8'd1, 16'h8001, 16'hF00F},
    '{2'd0, 4'd3,  8'd3, 16'h000B, 16'h0006},
    '{2'd0, 4'd12, 8'd2, 16'h1ABC, 16'h0F0F},
    '{2'd1, 4'd7,  8'd2, 16'h00C3, 16'h005A},
    '{2'd1, 4'd15, 8'd1, 16'h1234, 16'hABCD},
    '{2'd2, 4'd7,  8'd2, 16'h0096, 16'h00E7},
    '{2'd2, 4'd11, 8'd1, 16'h0041, 16'h0ABC},
    '{2'd0, 4'd1,  8'd1, 16'h0009, 16'h0005}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [15:0] cw(input logic [7:0] half, input logic en,
                                     input logic m, input logic [1:0] fmt, input logic [3:0] sz);
    return {half, en, m, fmt, sz};
  endfunction

  task automatic wait_idle(input string req);
    logic [15:0] s;
    bit done = 0;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, s);
      if (!s[4]) begin done = 1; break; end
    end
    if (!done) chk(req, 32'd1, 32'd0);
  endtask

  task automatic run_frame(input vec_t v, input string req);
    int n, r;
    logic [15:0] d;
    logic [31:0] mn, mr, exp_cap;
    n  = ((v.sz < 4'd3) ? 3 : int'(v.sz)) + 1;
    r  = (v.fmt == 2'd0) ? n : (v.fmt == 2'd1) ? n + 1 : n + 8;
    mn = (32'd1 << n) - 32'd1;
    mr = (r == 32) ? 32'hFFFF_FFFF : ((32'd1 << r) - 32'd1);
    exp_cap = (v.fmt == 2'd2) ? (32'(v.tx[7:0]) << n) : (32'(v.tx) & mn);
    @(negedge clk);
    slave_tb = 1'b0; sdi_const_mode = 1'b0;
    resp_vec = 32'(v.resp) << (32 - r);
    rises = 0; cap = 32'd0;
    wr(2'd0, cw(v.half, 1'b1, 1'b1, v.fmt, v.sz));
    wr(2'd1, v.tx);
    wait_idle(req);
    rd(2'd1, d);
    chk({req, " received word"}, 32'(d), 32'(v.resp) & mn);
    chk({req, " transmitted bits"}, cap & mr, exp_cap);
    chk({req, " clock count"}, 32'(rises), 32'(r));
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        oe_bad;
    logic [7:0]  got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state and control readback
    chk("R1 sclk_o after reset", 32'(sclk_o), 32'd0);
    chk("R1 sel_o after reset", 32'(sel_o), 32'd1);
    chk("R1 sdo_oe after reset", 32'(sdo_oe), 32'd0);
    rd(2'd0, d); chk("R1 control reset", 32'(d), 32'd0);
    rd(2'd2, d); chk("R1 status reset", 32'(d), 32'h3);
    wr(2'd0, 16'h4A27);
    rd(2'd0, d); chk("R1 control readback", 32'(d), 32'h4A27);
    wr(2'd0, 16'h0000);

    // vector table: R4 (SPI), R6 (sync), R7 (Microwire), R5 via small sizes
    for (int i = 0; i < NV; i++) begin
      string req;
      req = (VEC[i].fmt == 2'd0) ? "R4" : (VEC[i].fmt == 2'd1) ? "R6" : "R7";
      if (VEC[i].sz < 4'd4 || VEC[i].sz == 4'd15) req = {req, "/R5"};
      run_frame(VEC[i], req);
    end

    // R3: clock divide
    run_frame('{2'd0, 4'd7, 8'd3, 16'h0055, 16'h00AA}, "R3");
    chk("R3 period with divider 3", 32'(last_t - prev_t), 32'd60);
    run_frame('{2'd0, 4'd7, 8'd0, 16'h0033, 16'h00CC}, "R3");
    chk("R3 period with divider 0", 32'(last_t - prev_t), 32'd20);

    // R6: frame-sync pulse width
    run_frame('{2'd1, 4'd5, 8'd3, 16'h0029, 16'h0016}, "R6");
    chk("R6 sync pulse width", 32'(fs_dn - fs_up), 32'd60);
    chk("R6 sync idle low", 32'(sel_o), 32'd0);

    // R11: busy while transfer pending
    wr(2'd0, cw(8'd8, 1'b1, 1'b1, 2'd0, 4'd7));
    wr(2'd1, 16'h0011);
    rd(2'd2, d); chk("R11 busy during frame", 32'(d[4]), 32'd1);
    wait_idle("R11");
    rd(2'd2, d); chk("R11 busy clear after frame", 32'(d[4]), 32'd0);
    rd(2'd1, d);

    // R2 / R10: queue depth and overrun
    wr(2'd0, cw(8'd1, 1'b0, 1'b1, 2'd0, 4'd7));
    for (int i = 0; i < 9; i++) wr(2'd1, 16'(8'h10 + i));
    rd(2'd2, d);
    chk("R2 transmit queue full", 32'(d[1:0]), 32'd0);
    @(negedge clk);
    sdi_const_mode = 1'b1; sdi_const = 1'b1; rises = 0;
    wr(2'd0, cw(8'd1, 1'b1, 1'b1, 2'd0, 4'd7));
    wait_idle("R2");
    chk("R2 ninth write dropped (clock count)", 32'(rises), 32'd64);
    chk("R2 last word sent", cap & 32'hFF, 32'h17);
    rd(2'd2, d);
    chk("R10 no overrun yet", 32'(d[3:2]), 32'b01);
    @(negedge clk); sdi_const = 1'b0;
    wr(2'd1, 16'h0055);
    wait_idle("R10");
    rd(2'd2, d);
    chk("R10 overrun flag set", 32'(d[3]), 32'd1);
    for (int i = 0; i < 8; i++) begin
      rd(2'd1, d);
      chk("R10 kept word", 32'(d), 32'hFF);
    end
    rd(2'd2, d);
    chk("R10 overflow word discarded", 32'(d[2]), 32'd0);
    chk("R10 flag still set", 32'(d[3]), 32'd1);
    wr(2'd2, 16'h0000);
    rd(2'd2, d);
    chk("R10 flag cleared", 32'(d[3]), 32'd0);

    // R8: SPI slave frame
    @(negedge clk);
    sdi_const_mode = 1'b0; slave_tb = 1'b1; sclk_seen = 1'b0;
    wr(2'd0, cw(8'd0, 1'b1, 1'b0, 2'd0, 4'd7));
    wr(2'd1, 16'h00A5);
    got = 8'd0; oe_bad = 1'b0;
    @(negedge clk); sel_i = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      sdi_drv = 1'(8'h3C >> b);
      repeat (8) @(negedge clk);
      got = {got[6:0], sdo};
      if (!sdo_oe) oe_bad = 1'b1;
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    sel_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 slave transmitted word", 32'(got), 32'hA5);
    chk("R9 slave output enabled in frame", 32'(oe_bad), 32'd0);
    chk("R9 slave output released after frame", 32'(sdo_oe), 32'd0);
    rd(2'd1, d);
    chk("R8 slave received word", 32'(d), 32'h3C);

    // R9: clocks while deselected are ignored
    oe_bad = 1'b0; sdi_drv = 1'b1;
    for (int b = 0; b < 8; b++) begin
      repeat (8) @(negedge clk);
      if (sdo_oe) oe_bad = 1'b1;
      sclk_i = 1'b1;
      repeat (8) @(negedge clk);
      if (sdo_oe) oe_bad = 1'b1;
      sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R9 deselected output stays off", 32'(oe_bad), 32'd0);
    rd(2'd2, d);
    chk("R9 deselected receives nothing", 32'(d[2]), 32'd0);
    chk("R12 slave never drives sclk_o", 32'(sclk_seen), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule